// File: doc/BRIEF.md
# Hashed Direct-Mapped Instruction TLB

This block translates instruction-fetch addresses from effective to real form for a fetch pipeline. It holds 64 translations in a direct-mapped array. The slot for an address is chosen by folding three 6-bit page-number fields together with XOR, so pages that share their low index bits still spread across the array. A fetch returns its result one clock later: either the real address or a fetch-failed flag. The flag is raised on a translation miss in virtual mode, or when a supervisor-only page is fetched in problem state. A later fault stage turns that flag into an instruction-storage interrupt at vector 0x400.

Translation mode and privilege level come in with redirects. They are latched only when a redirect is presented, so a mode change takes effect at the next redirect. A command port installs a page-table entry or invalidates one slot. Installs whose entry grants no execute right, or whose reference bit is clear, are dropped before they reach the array.

Top module: `itlb_hashed`

## Requirements
- R1: After reset, out_valid and out_fail are 0, out_real_addr is 0, the latched mode is real mode and privileged, and every slot is empty.
- R2: In real mode a fetch returns out_real_addr equal to fetch_addr and out_fail 0, whatever the array holds.
- R3: The slot index is fetch or command address bits [17:12] XOR [23:18] XOR [29:24].
- R4: In virtual mode a hit returns, one cycle after the fetch, out_real_addr = {8'b0, pte[55:12], fetch_addr[11:0]} with out_fail 0.
- R5: In virtual mode, a fetch whose slot is empty or whose tag does not match gives out_fail 1 and out_real_addr 0.
- R6: A hit needs the stored tag to equal all of address bits [63:12]. Another page with the same index misses.
- R7: An invalidate command (cmd_install 0) clears the slot at its address's index without comparing the tag, and leaves other slots untouched.
- R8: If pte bit 3 is set, a fetch in problem state (latched privilege 0) fails even on a tag hit. A privileged fetch of the same page hits.
- R9: An install (cmd_install 1) whose pte has bit 0 (execute) or bit 8 (referenced) clear is ignored, and the slot keeps its previous contents.
- R10: redir_virt and redir_priv are taken only while redirect is 1. A fetch in the same cycle as the redirect uses the new mode, and without redirect the mode inputs have no effect.
- R11: out_valid follows fetch_valid one cycle later. With no fetch, out_fail and out_real_addr are 0.
- R12: An accepted install overwrites its slot, so an older page that mapped to the same index then misses.
- R13: A command takes effect for fetches presented in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect | input | 1 | Redirect strobe; latches the mode inputs |
| redir_virt | input | 1 | Translation enable carried by a redirect |
| redir_priv | input | 1 | Privileged (1) or problem state (0) carried by a redirect |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_addr | input | 64 | Effective fetch address |
| cmd_valid | input | 1 | A maintenance command is presented |
| cmd_install | input | 1 | 1 = install pte, 0 = invalidate slot |
| cmd_addr | input | 64 | Effective address selecting the slot and tag |
| cmd_pte | input | 64 | Page-table entry for installs |
| out_valid | output | 1 | Result of the fetch from the previous cycle |
| out_fail | output | 1 | Fetch failed (miss or privilege violation) |
| out_real_addr | output | 64 | Real address, 0 on failure |

## Verification
A corrupted slot, a stale valid bit, or a wrong hash field shows at the ports on the first virtual-mode fetch that lands on that slot. It appears one cycle later as an unexpected fail or a wrong real page number. The stimulus uses colliding addresses to expose this: one page evicts or invalidates another, which separates full-tag checks from index-only checks. A wrongly latched mode register shows on the next fetch after the redirect, as a pass-through address where a translated one was due, or the reverse. Dropped or accepted installs are observed by fetching the slot afterwards.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
    localparam int ADDR_W     = 64;
    localparam int PAGE_SHIFT = 12;
    localparam int IDX_W      = 6;
    localparam int NUM_FOLD   = 3;
    localparam int RA_W       = 56;
    localparam int TAG_W      = ADDR_W - PAGE_SHIFT;
    localparam int RPN_W      = RA_W - PAGE_SHIFT;
    localparam int HASH_W     = NUM_FOLD * IDX_W;

    localparam int PTE_EXEC_BIT = 0;
    localparam int PTE_PRIV_BIT = 3;
    localparam int PTE_REF_BIT  = 8;

    typedef struct packed {
        logic             valid;
        logic             priv;
        logic [TAG_W-1:0] tag;
        logic [RPN_W-1:0] rpn;
    } tlb_entry_t;

    typedef enum logic {
        CMD_INVAL   = 1'b0,
        CMD_INSTALL = 1'b1
    } cmd_kind_e;
endpackage

// File: rtl/itlb_hash.sv
module itlb_hash #(
    parameter int IDX_W    = 6,
    parameter int NUM_FOLD = 3,
    localparam int FIELD_W = IDX_W * NUM_FOLD
) (
    input  logic [FIELD_W-1:0] page_bits,
    output logic [IDX_W-1:0]   index
);
    logic [IDX_W-1:0] slice [NUM_FOLD];

    for (genvar g = 0; g < NUM_FOLD; g++) begin : g_slice
        assign slice[g] = page_bits[g*IDX_W +: IDX_W];
    end

    always_comb begin
        index = '0;
        for (int i = 0; i < NUM_FOLD; i++) begin
            index = index ^ slice[i];
        end
    end
endmodule

// File: rtl/itlb_pte_screen.sv
module itlb_pte_screen
    import itlb_pkg::*;
(
    input  logic [63:0]      pte,
    output logic             exec_ok,
    output logic             priv_only,
    output logic [RPN_W-1:0] real_page
);
    logic pte_unused;

    assign exec_ok    = pte[PTE_EXEC_BIT] & pte[PTE_REF_BIT];
    assign priv_only  = pte[PTE_PRIV_BIT];
    assign real_page  = pte[RA_W-1:PAGE_SHIFT];
    assign pte_unused = ^{pte[63:RA_W], pte[PAGE_SHIFT-1:PTE_REF_BIT+1],
                          pte[PTE_REF_BIT-1:PTE_PRIV_BIT+1],
                          pte[PTE_PRIV_BIT-1:PTE_EXEC_BIT+1]};
endmodule

// File: rtl/itlb_store.sv
module itlb_store
    import itlb_pkg::*;
#(
    parameter int IDX_W    = 6,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output tlb_entry_t       rd_entry
);
    tlb_entry_t slot_d [ENTRIES];
    tlb_entry_t slot_q [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            slot_d[i] = slot_q[i];
        end
        if (clr_en) begin
            slot_d[clr_idx].valid = 1'b0;
        end
        if (wr_en) begin
            slot_d[wr_idx] = wr_entry;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d[i];
        end
    end

    assign rd_entry = slot_q[rd_idx];
endmodule

// File: rtl/itlb_hashed.sv
module itlb_hashed
    import itlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        redirect,
    input  logic        redir_virt,
    input  logic        redir_priv,
    input  logic        fetch_valid,
    input  logic [63:0] fetch_addr,
    input  logic        cmd_valid,
    input  logic        cmd_install,
    input  logic [63:0] cmd_addr,
    input  logic [63:0] cmd_pte,
    output logic        out_valid,
    output logic        out_fail,
    output logic [63:0] out_real_addr
);
    typedef struct packed {
        logic              mode_virt;
        logic              mode_priv;
        logic              res_valid;
        logic              res_fail;
        logic [ADDR_W-1:0] res_addr;
    } state_t;

    state_t st_d, st_q;

    logic             mode_virt_q;
    logic             eff_virt;
    logic             eff_priv;
    logic [IDX_W-1:0] fetch_idx;
    logic [IDX_W-1:0] cmd_idx;
    tlb_entry_t       rd_entry;
    tlb_entry_t       new_entry;
    logic             pte_exec_ok;
    logic             pte_priv;
    logic [RPN_W-1:0] pte_rpn;
    logic             tag_hit;
    logic             xlate_fail;
    logic             wr_en;
    logic             clr_en;
    logic [ADDR_W-1:0] xlate_addr;
    logic             cmd_unused;

    assign mode_virt_q = st_q.mode_virt;
    assign eff_virt    = redirect ? redir_virt : st_q.mode_virt;
    assign eff_priv    = redirect ? redir_priv : st_q.mode_priv;
    assign cmd_unused  = ^cmd_addr[PAGE_SHIFT-1:0];

    itlb_hash #(.IDX_W(IDX_W), .NUM_FOLD(NUM_FOLD)) u_fetch_hash (
        .page_bits (fetch_addr[PAGE_SHIFT +: HASH_W]),
        .index     (fetch_idx)
    );

    itlb_hash #(.IDX_W(IDX_W), .NUM_FOLD(NUM_FOLD)) u_cmd_hash (
        .page_bits (cmd_addr[PAGE_SHIFT +: HASH_W]),
        .index     (cmd_idx)
    );

    itlb_pte_screen u_screen (
        .pte       (cmd_pte),
        .exec_ok   (pte_exec_ok),
        .priv_only (pte_priv),
        .real_page (pte_rpn)
    );

    always_comb begin
        new_entry.valid = 1'b1;
        new_entry.priv  = pte_priv;
        new_entry.tag   = cmd_addr[ADDR_W-1:PAGE_SHIFT];
        new_entry.rpn   = pte_rpn;
        wr_en  = cmd_valid && (cmd_kind_e'(cmd_install) == CMD_INSTALL) && pte_exec_ok;
        clr_en = cmd_valid && (cmd_kind_e'(cmd_install) == CMD_INVAL);
    end

    itlb_store #(.IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (cmd_idx),
        .wr_entry (new_entry),
        .clr_en   (clr_en),
        .clr_idx  (cmd_idx),
        .rd_idx   (fetch_idx),
        .rd_entry (rd_entry)
    );

    always_comb begin
        tag_hit    = rd_entry.valid && (rd_entry.tag == fetch_addr[ADDR_W-1:PAGE_SHIFT]);
        xlate_fail = !tag_hit || (rd_entry.priv && !eff_priv);
        xlate_addr = {{(ADDR_W-RA_W){1'b0}}, rd_entry.rpn, fetch_addr[PAGE_SHIFT-1:0]};

        st_d           = st_q;
        st_d.mode_virt = eff_virt;
        st_d.mode_priv = eff_priv;
        st_d.res_valid = fetch_valid;
        st_d.res_fail  = 1'b0;
        st_d.res_addr  = '0;
        if (fetch_valid) begin
            if (!eff_virt) begin
                st_d.res_addr = fetch_addr;
            end else if (xlate_fail) begin
                st_d.res_fail = 1'b1;
            end else begin
                st_d.res_addr = xlate_addr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.mode_priv <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid     = st_q.res_valid;
    assign out_fail      = st_q.res_fail;
    assign out_real_addr = st_q.res_addr;
endmodule

// File: rtl/itlb_hashed_chk.sv
module itlb_hashed_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        redirect,
    input logic        redir_virt,
    input logic        fetch_valid,
    input logic [63:0] fetch_addr,
    input logic        out_valid,
    input logic        out_fail,
    input logic [63:0] out_real_addr,
    input logic        mode_virt_q
);
    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> out_valid); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (!out_valid && !out_fail && out_real_addr == 64'd0)); // R11
    AST_REAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && redirect && !redir_virt) |=>
            (!out_fail && out_real_addr == $past(fetch_addr))); // R2
    AST_FAIL_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_fail |-> (out_valid && out_real_addr == 64'd0)); // R5
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect |=> $stable(mode_virt_q)); // R10
    AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (mode_virt_q == $past(redir_virt))); // R10
endmodule

bind itlb_hashed itlb_hashed_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .redirect      (redirect),
    .redir_virt    (redir_virt),
    .fetch_valid   (fetch_valid),
    .fetch_addr    (fetch_addr),
    .out_valid     (out_valid),
    .out_fail      (out_fail),
    .out_real_addr (out_real_addr),
    .mode_virt_q   (mode_virt_q)
);

// File: tb/itlb_hashed_bench.sv
module itlb_hashed_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        redirect, redir_virt, redir_priv;
    logic        fetch_valid;
    logic [63:0] fetch_addr;
    logic        cmd_valid, cmd_install;
    logic [63:0] cmd_addr, cmd_pte;
    logic        out_valid, out_fail;
    logic [63:0] out_real_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    itlb_hashed u_itlb_hashed (
        .clk(clk), .rst_n(rst_n), .redirect(redirect), .redir_virt(redir_virt),
        .redir_priv(redir_priv), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .cmd_valid(cmd_valid), .cmd_install(cmd_install), .cmd_addr(cmd_addr),
        .cmd_pte(cmd_pte), .out_valid(out_valid), .out_fail(out_fail),
        .out_real_addr(out_real_addr)
    );

    localparam logic [1:0] K_MODE = 2'd0, K_FETCH = 2'd1, K_INST = 2'd2, K_INVAL = 2'd3;

    typedef struct packed {
        logic [1:0]  kind;
        logic        virt;
        logic        priv;
        logic [63:0] addr;
        logic [63:0] pte;
        logic        exp_fail;
        logic [63:0] exp_ra;
        logic [7:0]  req;
    } vec_t;

    localparam logic [63:0] PG_A = 64'h0000_0000_0000_1000; // index 1
    localparam logic [63:0] PG_B = 64'h0000_0000_0004_0000; // index 1, other tag
    localparam logic [63:0] PG_C = 64'h1234_0000_3F29_5000; // 0x15^0x0A^0x3F = 0x20
    localparam logic [63:0] PG_Y = 64'h0000_0000_0002_0000; // index 0x20
    localparam logic [63:0] PG_D = 64'h0000_0000_0000_5000;
    localparam logic [63:0] PG_E = 64'h0000_0000_0000_7000;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{K_FETCH, 1'b0, 1'b0, PG_A + 64'h234, 64'h0, 1'b0, PG_A + 64'h234, 8'd2},     // R2
        '{K_MODE,  1'b1, 1'b1, 64'h0, 64'h0, 1'b0, 64'h0, 8'd10},                      // R10
        '{K_FETCH, 1'b0, 1'b0, PG_A + 64'h234, 64'h0, 1'b1, 64'h0, 8'd5},              // R5, R1
        '{K_INST,  1'b0, 1'b0, PG_A, 64'h0000_0000_0ABC_D101, 1'b0, 64'h0, 8'd4},
        '{K_FETCH, 1'b0, 1'b0, PG_A + 64'h234, 64'h0, 1'b0, 64'h0ABC_D234, 8'd4},      // R4
        '{K_FETCH, 1'b0, 1'b0, PG_B, 64'h0, 1'b1, 64'h0, 8'd6},                        // R6
        '{K_INST,  1'b0, 1'b0, PG_C, 64'h0000_0000_1111_1101, 1'b0, 64'h0, 8'd3},
        '{K_FETCH, 1'b0, 1'b0, PG_C + 64'hFFC, 64'h0, 1'b0, 64'h1111_1FFC, 8'd3},      // R3
        '{K_INVAL, 1'b0, 1'b0, PG_Y, 64'h0, 1'b0, 64'h0, 8'd7},
        '{K_FETCH, 1'b0, 1'b0, PG_C + 64'hFFC, 64'h0, 1'b1, 64'h0, 8'd7},              // R7
        '{K_FETCH, 1'b0, 1'b0, PG_A + 64'h234, 64'h0, 1'b0, 64'h0ABC_D234, 8'd7},      // R7
        '{K_INST,  1'b0, 1'b0, PG_B, 64'h0000_0000_0022_2101, 1'b0, 64'h0, 8'd12},
        '{K_FETCH, 1'b0, 1'b0, PG_A + 64'h234, 64'h0, 1'b1, 64'h0, 8'd12},             // R12
        '{K_FETCH, 1'b0, 1'b0, PG_B + 64'h10, 64'h0, 1'b0, 64'h0022_2010, 8'd12},      // R12
        '{K_INST,  1'b0, 1'b0, PG_E, 64'h0000_0000_0333_3001, 1'b0, 64'h0, 8'd9},
        '{K_FETCH, 1'b0, 1'b0, PG_E, 64'h0, 1'b1, 64'h0, 8'd9},                        // R9
        '{K_INST,  1'b0, 1'b0, PG_D, 64'h0000_0000_0077_7109, 1'b0, 64'h0, 8'd8},
        '{K_FETCH, 1'b0, 1'b0, PG_D, 64'h0, 1'b0, 64'h0077_7000, 8'd8},                // R8
        '{K_MODE,  1'b1, 1'b0, 64'h0, 64'h0, 1'b0, 64'h0, 8'd10},
        '{K_FETCH, 1'b0, 1'b0, PG_D, 64'h0, 1'b1, 64'h0, 8'd8},                        // R8
        '{K_INST,  1'b0, 1'b0, PG_E, 64'h0000_0000_0044_4101, 1'b0, 64'h0, 8'd8},
        '{K_FETCH, 1'b0, 1'b0, PG_E + 64'h8, 64'h0, 1'b0, 64'h0044_4008, 8'd8},        // R8
        '{K_INST,  1'b0, 1'b0, PG_E, 64'h0000_0000_0055_5100, 1'b0, 64'h0, 8'd9},
        '{K_FETCH, 1'b0, 1'b0, PG_E + 64'h8, 64'h0, 1'b0, 64'h0044_4008, 8'd9}         // R9
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        redirect = 1'b0; redir_virt = 1'b0; redir_priv = 1'b0;
        fetch_valid = 1'b0; fetch_addr = '0;
        cmd_valid = 1'b0; cmd_install = 1'b0; cmd_addr = '0; cmd_pte = '0;
    endtask

    task automatic fetch(input logic redir, input logic v, input logic p, input logic [63:0] a);
        idle_inputs();
        redirect = redir; redir_virt = v; redir_priv = p;
        fetch_valid = 1'b1; fetch_addr = a;
        @(negedge clk);
    endtask

    task automatic command(input logic inst, input logic [63:0] a, input logic [63:0] pte);
        idle_inputs();
        cmd_valid = 1'b1; cmd_install = inst; cmd_addr = a; cmd_pte = pte;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle_inputs();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid", {63'd0, out_valid}, 64'd0);
        check("R1 out_fail", {63'd0, out_fail}, 64'd0);
        check("R1 out_real_addr", out_real_addr, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            idle_inputs();
            case (VECS[i].kind)
                K_MODE: begin
                    redirect = 1'b1; redir_virt = VECS[i].virt; redir_priv = VECS[i].priv;
                    @(negedge clk);
                end
                K_INST:  command(1'b1, VECS[i].addr, VECS[i].pte);
                K_INVAL: command(1'b0, VECS[i].addr, VECS[i].pte);
                default: begin
                    fetch(1'b0, 1'b0, 1'b0, VECS[i].addr);
                    check($sformatf("R%0d fail vec %0d", VECS[i].req, i),
                          {63'd0, out_fail}, {63'd0, VECS[i].exp_fail});
                    check($sformatf("R%0d addr vec %0d", VECS[i].req, i),
                          out_real_addr, VECS[i].exp_ra);
                end
            endcase
        end

        // R10: mode inputs without redirect are ignored (mode is virt, problem state)
        fetch(1'b0, 1'b0, 1'b1, PG_E + 64'h8);
        check("R10 no-redirect ignored", out_real_addr, 64'h0044_4008);
        fetch(1'b1, 1'b0, 1'b1, PG_D + 64'h5);
        check("R10 same-cycle real", out_real_addr, PG_D + 64'h5);
        fetch(1'b0, 1'b1, 1'b0, PG_C);
        check("R10 stays real", {out_fail, out_real_addr[62:0]}, {1'b0, PG_C[62:0]});
        fetch(1'b1, 1'b1, 1'b1, PG_D);
        check("R10 back to virt privileged", out_real_addr, 64'h0077_7000);

        // R13: install and fetch in the same cycle, fetch sees old contents
        idle_inputs();
        cmd_valid = 1'b1; cmd_install = 1'b1; cmd_addr = PG_Y; cmd_pte = 64'h0000_0000_0099_9101;
        fetch_valid = 1'b1; fetch_addr = PG_Y;
        @(negedge clk);
        check("R13 same-cycle miss", {63'd0, out_fail}, 64'd1);
        fetch(1'b0, 1'b0, 1'b0, PG_Y + 64'h44);
        check("R13 next-cycle hit", out_real_addr, 64'h0099_9044);

        // R11: idle cycle
        idle_inputs();
        @(negedge clk);
        check("R11 idle valid", {63'd0, out_valid}, 64'd0);
        check("R11 idle fail", {63'd0, out_fail}, 64'd0);

        // R1: reset empties the array and returns to real mode
        idle_inputs();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fetch(1'b0, 1'b0, 1'b0, PG_B + 64'h10);
        check("R1 real after reset", out_real_addr, PG_B + 64'h10);
        fetch(1'b1, 1'b1, 1'b1, PG_B + 64'h10);
        check("R1 empty after reset", {63'd0, out_fail}, 64'd1);

        idle_inputs();
        @(negedge clk);
        finish_run();
    end
endmodule